// File: doc/BRIEF.md
# Serial Bit-Rate Clock Generator

This block makes the shift clock for one serial channel. The system clock first passes through a prescaler whose ratio is chosen by a 3-bit code. A parameter picks which of two ratio tables the code indexes. The prescaler ticks then step an 8-bit down-counter that reloads itself. Each time that counter wraps, an output flip-flop toggles, so the internal bit clock runs at half the wrap rate.

A source decision picks between this internal clock and an external clock pin. The external pin first passes through a two-stage synchronizer. The decision depends on the operating mode and on a source-select register that software writes. That register has no reset value. The decision is captured only while the block is disabled, so the output never switches source while it is running. A channel can be built as asynchronous-only, and then the external pin is never used.

Top module: `sclk_gen`

## Requirements
- R1: With the internal source selected and the block enabled, the period of `sclk_o` is 2 × (`rld_i` + 1) × P system clocks, where P is the prescaler ratio. The output toggles exactly once on each counter wrap and holds its level between wraps.
- R2: With `TABLE_B` = 0, `code_i` values 0 to 7 select P = 2, 4, 8, 16, 32, 64, 2048 and 4096.
- R3: With `TABLE_B` = 1, `code_i` values 0 to 7 select P = 2, 4, 8, 16, 32, 64, 128 and 256.
- R4: While `en_i` is 0, `sclk_o` is 0. Both counters restart from their initial state on the next enable.
- R5: In asynchronous mode (`mode_i` = 2'b00), a source-select value of 0 selects the internal clock and a value of 1 selects the external pin.
- R6: In clock-synchronized master mode (`mode_i` = 2'b01), the internal clock is used whatever the select value is. The unused code 2'b11 behaves the same way.
- R7: In clock-synchronized slave mode (`mode_i` = 2'b10), `sclk_o` follows `ext_clk_i` through two register stages, so an input change shows at the output two clock edges later.
- R8: With `ASYNC_ONLY` = 1, the external pin is never used, in any mode and for any select value.
- R9: The source decision is captured only while `en_i` is 0. Changes to `mode_i` or to the select register while the block is enabled have no effect until the block has been disabled and enabled again.
- R10: The source-select register is loaded from `sel_d_i` when `sel_we_i` is 1. It has no reset value and keeps its contents across disable and enable. It must be written after reset before `en_i` is first raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| en_i | input | 1 | Runs the clock generator; 0 holds the output low |
| mode_i | input | 2 | 00 asynchronous, 01 synchronous master, 10 synchronous slave, 11 as master |
| code_i | input | 3 | Prescaler ratio code |
| rld_i | input | RLD_W | Counter reload value |
| sel_we_i | input | 1 | Write strobe for the source-select register |
| sel_d_i | input | 1 | Source-select value: 0 internal, 1 external |
| ext_clk_i | input | 1 | External serial clock pin |
| sclk_o | output | 1 | Serial shift clock |

## Verification
The assertions check on every cycle that the output stays low while disabled and that the internal clock toggles on a counter wrap and at no other time. They also check that the latched source stays frozen while the block is enabled, that the external path has a latency of exactly two edges, that an asynchronous-only channel never picks the external pin, and that the select register was written before the first enable. Only the bench scenarios can show the measured output periods against the rate equation for both ratio tables. The same holds for the source chosen under each mode and select combination, and for the fact that mode changes made while the block is running do not take effect.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

  localparam int PRE_W = 13;

  typedef enum logic [1:0] {
    MODE_ASYNC    = 2'b00,
    MODE_SYNC_MST = 2'b01,
    MODE_SYNC_SLV = 2'b10,
    MODE_RSVD     = 2'b11
  } sclk_mode_e;

  // Prescaler division ratio for a given code; the top two codes differ per table.
  function automatic logic [PRE_W-1:0] pre_ratio(input logic [2:0] code, input bit table_b);
    logic [PRE_W-1:0] r;
    case (code)
      3'd0: r = 13'd2;
      3'd1: r = 13'd4;
      3'd2: r = 13'd8;
      3'd3: r = 13'd16;
      3'd4: r = 13'd32;
      3'd5: r = 13'd64;
      3'd6: r = table_b ? 13'd128 : 13'd2048;
      default: r = table_b ? 13'd256 : 13'd4096;
    endcase
    return r;
  endfunction

  // Source decision: 1 means the external pin drives the output.
  function automatic logic want_external(input sclk_mode_e mode, input logic sel,
                                         input bit async_only);
    logic r;
    if (async_only) r = 1'b0;
    else begin
      case (mode)
        MODE_ASYNC:    r = sel;
        MODE_SYNC_SLV: r = 1'b1;
        default:       r = 1'b0;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
  import sclk_pkg::*;
#(
  parameter bit TABLE_B = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] code_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] last_w;

  assign last_w = pre_ratio(code_i, TABLE_B) - 1'b1;
  assign tick_o = en_i && (cnt_q >= last_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sclk_reload_timer.sv
module sclk_reload_timer #(
  parameter int RLD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [RLD_W-1:0] rld_i,
  output logic             zero_o,
  output logic             clk_o
);
  logic [RLD_W-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= rld_i;
      clk_o <= 1'b0;
    end else if (tick_i) begin
      if (zero_o) begin
        cnt_q <= rld_i;
        clk_o <= ~clk_o;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sclk_sync.sv
module sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_pkg::*;
#(
  parameter int RLD_W       = 8,
  parameter bit TABLE_B     = 1'b0,
  parameter bit ASYNC_ONLY  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic [2:0]       code_i,
  input  logic [RLD_W-1:0] rld_i,
  input  logic             sel_we_i,
  input  logic             sel_d_i,
  input  logic             ext_clk_i,
  output logic             sclk_o
);
  // Named internal events, observed by the bound checker.
  logic pre_tick;
  logic tmr_zero;
  logic int_clk;
  logic ext_s;
  logic use_ext;
  logic sel_q;

  // Source-select register: deliberately without reset.
  always_ff @(posedge clk_i) begin
    if (sel_we_i) sel_q <= sel_d_i;
  end

  // Source decision is captured only while idle, so the mux never moves mid-run.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    use_ext <= 1'b0;
    else if (!en_i) use_ext <= want_external(sclk_mode_e'(mode_i), sel_q, ASYNC_ONLY);
  end

  sclk_prescaler #(.TABLE_B(TABLE_B)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .code_i(code_i),
    .tick_o(pre_tick)
  );

  sclk_reload_timer #(.RLD_W(RLD_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .tick_i(pre_tick),
    .rld_i (rld_i),
    .zero_o(tmr_zero),
    .clk_o (int_clk)
  );

  sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_clk_i),
    .q_o   (ext_s)
  );

  assign sclk_o = en_i & (use_ext ? ext_s : int_clk);
endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk #(
  parameter bit ASYNC_ONLY  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic sel_we_i,
  input logic ext_clk_i,
  input logic sclk_o,
  input logic pre_tick,
  input logic tmr_zero,
  input logic int_clk,
  input logic use_ext
);
  logic sel_written;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_written <= 1'b0;
    else if (sel_we_i) sel_written <= 1'b1;
  end

  // R4
  a_r4_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !sclk_o);

  // R1: toggle on wrap
  a_r1_toggle_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pre_tick && tmr_zero) |=> (int_clk != $past(int_clk)));

  // R1: hold between wraps
  a_r1_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !(pre_tick && tmr_zero)) |=> $stable(int_clk));

  // R9
  a_r9_src_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> $stable(use_ext));

  // R10
  a_r10_sel_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> sel_written);

  // R8
  always_comb begin
    if (rst_ni && ASYNC_ONLY) begin
      a_r8_no_external: assert (!use_ext);
    end
  end

  // R7
  generate
    if (SYNC_STAGES == 2) begin : g_lat
      a_r7_ext_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && use_ext && $past(rst_ni, 2)) |-> (sclk_o == $past(ext_clk_i, 2)));
    end
  endgenerate
endmodule

bind sclk_gen sclk_gen_chk #(.ASYNC_ONLY(ASYNC_ONLY), .SYNC_STAGES(SYNC_STAGES)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .sel_we_i (sel_we_i),
  .ext_clk_i(ext_clk_i),
  .sclk_o   (sclk_o),
  .pre_tick (pre_tick),
  .tmr_zero (tmr_zero),
  .int_clk  (int_clk),
  .use_ext  (use_ext)
);

// File: tb/test_sclk_gen.sv
module test_sclk_gen;
  localparam int CLK_PERIOD = 10;
  localparam int EXT_HALF   = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] en;
  logic [1:0] mode [2];
  logic [2:0] code [2];
  logic [7:0] rld  [2];
  logic [1:0] sel_we;
  logic [1:0] sel_d;
  logic       ext = 1'b0;
  logic       ext_run = 1'b0;
  wire  [1:0] sclk;

  int n_tests = 0;
  int n_fail  = 0;
  int done_cnt = 0;

  typedef struct { int k; int exp; string tag; } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sclk_gen #(.TABLE_B(1'b0), .ASYNC_ONLY(1'b0)) i_sclk_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en[0]), .mode_i(mode[0]), .code_i(code[0]),
    .rld_i(rld[0]), .sel_we_i(sel_we[0]), .sel_d_i(sel_d[0]), .ext_clk_i(ext),
    .sclk_o(sclk[0]));

  sclk_gen #(.TABLE_B(1'b1), .ASYNC_ONLY(1'b1)) i_sclk_gen_b (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en[1]), .mode_i(mode[1]), .code_i(code[1]),
    .rld_i(rld[1]), .sel_we_i(sel_we[1]), .sel_d_i(sel_d[1]), .ext_clk_i(ext),
    .sclk_o(sclk[1]));

  function automatic int ratio_tb(int c, bit b);
    int base [6] = '{2, 4, 8, 16, 32, 64};
    if (c < 6) return base[c];
    if (b) return (c == 6) ? 128 : 256;
    return (c == 6) ? 2048 : 4096;
  endfunction

  function automatic int period_tb(int c, int r, bit b);
    return 2 * (r + 1) * ratio_tb(c, b);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sel_write(int k, logic v);
    @(negedge clk); sel_we[k] = 1'b1; sel_d[k] = v;
    @(negedge clk); sel_we[k] = 1'b0;
  endtask

  // Driver: configure, enable, push the expected period, wait for the monitor.
  task automatic run(int k, logic [1:0] m, int c, int r, int exp, string tag);
    item_t it;
    int start;
    @(negedge clk);
    mode[k] = m; code[k] = c[2:0]; rld[k] = r[7:0];
    @(negedge clk);
    en[k] = 1'b1;
    it.k = k; it.exp = exp; it.tag = tag;
    start = done_cnt;
    q.push_back(it);
    while (done_cnt == start) @(negedge clk);
    en[k] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // External clock source: period 2*EXT_HALF.
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      if (ext_run) begin
        div++;
        if (div == EXT_HALF) begin div = 0; ext = ~ext; end
      end
    end
  end

  // Monitor: measures one full period between two rising edges.
  initial begin
    forever begin
      item_t it;
      int cyc, rises;
      logic prev;
      while (q.size() == 0) @(negedge clk);
      it = q[0];
      cyc = 0; rises = 0; prev = sclk[it.k];
      while (rises < 2 && cyc < 30000) begin
        @(negedge clk);
        cyc++;
        if (!prev && sclk[it.k]) begin
          rises++;
          if (rises == 1) cyc = 0;
        end
        prev = sclk[it.k];
      end
      if (rises < 2) cyc = -1;
      chk(cyc == it.exp, it.tag, cyc, it.exp);
      void'(q.pop_front());
      done_cnt++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    en = '0; sel_we = '0; sel_d = '0;
    for (int k = 0; k < 2; k++) begin mode[k] = 2'b00; code[k] = 3'd0; rld[k] = 8'd0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk == 2'b00, "R4 reset low", int'(sclk), 0);

    sel_write(0, 1'b0);  // R10: written before first enable
    sel_write(1, 1'b1);

    // R1 / R2: table A
    run(0, 2'b00, 0, 0, period_tb(0, 0, 0), "R2 code0 rld0");
    run(0, 2'b00, 2, 5, period_tb(2, 5, 0), "R1 code2 rld5");
    run(0, 2'b00, 6, 0, period_tb(6, 0, 0), "R2 code6");
    run(0, 2'b00, 7, 0, period_tb(7, 0, 0), "R2 code7");
    run(0, 2'b00, 4, 3, period_tb(4, 3, 0), "R1 code4 rld3");

    // R3: table B
    run(1, 2'b00, 6, 3, period_tb(6, 3, 1), "R3 code6 rld3");
    run(1, 2'b00, 7, 0, period_tb(7, 0, 1), "R3 code7");
    run(1, 2'b00, 1, 9, period_tb(1, 9, 1), "R3 code1 rld9");

    // R4: idle after disable
    begin
      int bad = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (sclk != 2'b00) bad++; end
      chk(bad == 0, "R4 idle after disable", bad, 0);
    end

    ext_run = 1'b1;
    // R5
    run(0, 2'b00, 0, 0, period_tb(0, 0, 0), "R5 async sel0 internal");
    sel_write(0, 1'b1);
    run(0, 2'b00, 0, 0, 2 * EXT_HALF, "R5 async sel1 external");
    // R10: value kept across disable/enable without rewrite
    run(0, 2'b00, 0, 0, 2 * EXT_HALF, "R10 select kept");
    // R6
    run(0, 2'b01, 1, 1, period_tb(1, 1, 0), "R6 master ignores sel");
    run(0, 2'b11, 0, 0, period_tb(0, 0, 0), "R6 code 11 as master");
    // R7
    run(0, 2'b10, 7, 0, 2 * EXT_HALF, "R7 slave external");
    // R8
    run(1, 2'b00, 0, 0, period_tb(0, 0, 1), "R8 async-only sel1");
    run(1, 2'b10, 0, 1, period_tb(0, 1, 1), "R8 async-only slave");

    // R7: two-edge latency
    ext_run = 1'b0;
    @(negedge clk); ext = 1'b0;
    @(negedge clk); mode[0] = 2'b10;
    repeat (3) @(negedge clk);
    en[0] = 1'b1;
    repeat (3) @(negedge clk);
    chk(sclk[0] == 1'b0, "R7 low before edge", int'(sclk[0]), 0);
    ext = 1'b1;
    @(negedge clk);
    chk(sclk[0] == 1'b0, "R7 one edge later", int'(sclk[0]), 0);
    @(negedge clk);
    chk(sclk[0] == 1'b1, "R7 two edges later", int'(sclk[0]), 1);
    en[0] = 1'b0;
    ext = 1'b0;
    repeat (3) @(negedge clk);

    // R9: change mode and select while running; internal source stays
    sel_write(0, 1'b0);
    ext_run = 1'b1;
    @(negedge clk); mode[0] = 2'b00; code[0] = 3'd0; rld[0] = 8'd0;
    @(negedge clk); en[0] = 1'b1;
    repeat (3) @(negedge clk);
    mode[0] = 2'b10;
    sel_we[0] = 1'b1; sel_d[0] = 1'b1;
    @(negedge clk); sel_we[0] = 1'b0;
    begin
      item_t it;
      int start;
      it.k = 0; it.exp = period_tb(0, 0, 0); it.tag = "R9 frozen source";
      start = done_cnt;
      q.push_back(it);
      while (done_cnt == start) @(negedge clk);
    end
    en[0] = 1'b0;
    repeat (3) @(negedge clk);
    // R9: takes effect after re-enable
    run(0, 2'b10, 0, 0, 2 * EXT_HALF, "R9 applied after re-enable");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule